// File: doc/BRIEF.md
# Leaf Divider Clear Sequencer

This block controls the safe reset of a group of leaf clock dividers that all sit behind one shared clock buffer. The dividers turn the buffer's clock into copies at one, one half, one quarter and one eighth of its rate. When the buffer, or the clock-shaping block that feeds it, has been reset, or when the clocked region has been reconfigured, the dividers must be cleared. Otherwise their phases no longer line up.

The sequencer runs on its own free-running control clock. When a request arrives, it first drives the buffer's synchronous clock enable low and waits long enough for that change to take effect on the buffer's own clock. Next it holds the active-low divider clear low for a programmed number of cycles, then releases it. It keeps the clock stopped for a settle interval that must exceed the worst-case route delay of the clear net. Only then does it raise the enable again and report completion with a one-cycle done pulse. A request that arrives while a sequence is running is remembered and served as one follow-up sequence.

Top module: `leaf_clr_seq`

## Requirements
- R1: On leaving the idle state, `buf_ce_o` goes low while `leaf_clr_n_o` stays high, for exactly STOP_CYC+1 control cycles, before the clear is driven.
- R2: `leaf_clr_n_o` is then held low for exactly CLR_CYC cycles (CLR_CYC is raised to 4 if set lower), and `buf_ce_o` stays low for all of that time.
- R3: After the clear returns high, `buf_ce_o` stays low for exactly SETTLE_CYC cycles. The default of 2 cycles gives 16 ns at 125 MHz, which is above the 10 ns minimum.
- R4: `done_o` is high for exactly one cycle, in the first cycle in which `buf_ce_o` is high again. `busy_o` (1 = sequence running, 0 = ready) is high from the first stop cycle through the done cycle, and is low in idle.
- R5: Any number of requests seen while a sequence is running merge into one follow-up sequence. That sequence starts after exactly one idle cycle.
- R6: While the synchronous active-low reset `rst_n` is low, the outputs are `buf_ce_o`=0, `leaf_clr_n_o`=0, `busy_o`=1 and `done_o`=0, and `clr_req_i` is ignored. After release, the clear phase completes, and then the settle, done and idle phases follow, with no further sequence.
- R7: A request seen in the done cycle counts as pending. It starts a new sequence after one idle cycle.
- R8: No buffer clock edge reaches the dividers while the clear is low or during the settle interval. At clear release, every divided output (ratio 2, 4 and 8) reads high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_req_i | input | 1 | Request for a clear sequence, sampled each cycle |
| busy_o | output | 1 | High while a sequence runs; low means ready |
| done_o | output | 1 | One-cycle pulse when the clock is re-enabled |
| buf_ce_o | output | 1 | Synchronous clock enable to the shared buffer |
| leaf_clr_n_o | output | 1 | Active-low clear to all leaf dividers |

## Verification
Two events can fall on the same control cycle. One is a new request on `clr_req_i`. The other is the end of a running sequence, when the done pulse is issued and the pending flag is being consumed. The bench provokes this by waiting for `done_o` at a sampling point and driving the request inside that same cycle. A scoreboard of expected output phases then demands exactly one idle cycle, followed by a complete stop, clear and settle run. The same check is made against requests landing mid-sequence, and against a reset that cuts a sequence short.

// File: rtl/lcs_pkg.sv
// Package: shared state type and output decode for the leaf divider clear
// sequencer. Assumes every output is a pure function of the state.
package lcs_pkg;

    typedef enum logic [2:0] {
        S_IDLE         = 3'd0,
        S_STOP_CLK     = 3'd1,
        S_WAIT_STOP    = 3'd2,
        S_ASSERT_CLR   = 3'd3,
        S_HOLD_CLR     = 3'd4,
        S_RELEASE_WAIT = 3'd5,
        S_ENABLE       = 3'd6
    } seq_state_t;

    typedef struct packed {
        logic ce;
        logic clr_n;
        logic busy;
        logic done;
    } seq_out_t;

    // Map a state to the output levels it drives.
    function automatic seq_out_t decode_out(seq_state_t s);
        seq_out_t o;
        o.ce    = (s == S_IDLE) || (s == S_ENABLE);
        o.clr_n = !((s == S_ASSERT_CLR) || (s == S_HOLD_CLR));
        o.busy  = (s != S_IDLE);
        o.done  = (s == S_ENABLE);
        return o;
    endfunction

endpackage

// File: rtl/lcs_req_latch.sv
// Request latch: remembers any request until the sequencer takes it.
// Assumes take is asserted only in the cycle the sequencer leaves idle.
module lcs_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic take_i,
    output logic pend_o
);

    logic pend_q;

    // Set on any request, cleared when consumed; a same-cycle request wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= req_i | (pend_q & ~take_i);
    end

    assign pend_o = pend_q;

    // R5 / R7: a sampled request is always remembered.
    a_r5_req_latched: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> pend_q);

endmodule

// File: rtl/lcs_timer.sv
// Down-counter for phase lengths: loads a value, counts to zero and holds.
// Assumes the caller loads N-1 to stay N cycles in a timed state.
module lcs_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);

    logic [CW-1:0] cnt_q;

    // Load on request, otherwise decrement until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load_i)        cnt_q <= load_val_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R3: an expired timer never wraps around without a new load.
    a_r3_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/lcs_fsm.sv
// Sequencer state machine: stop clock, wait, clear, hold, release, settle,
// re-enable. Outputs are registered from the next state, so they never glitch.
// Assumes the timer counts N-1..0 after a load and reports zero at 0.
module lcs_fsm
    import lcs_pkg::*;
#(
    parameter int STOP_CYC   = 8,
    parameter int CLR_CYC    = 4,
    parameter int SETTLE_CYC = 2,
    parameter int CW         = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pend_i,
    input  logic          tmr_zero_i,
    output logic          take_o,
    output logic          tmr_load_o,
    output logic [CW-1:0] tmr_val_o,
    output logic          ce_o,
    output logic          clr_n_o,
    output logic          busy_o,
    output logic          done_o
);

    seq_state_t state_q, state_d;
    seq_out_t   out_q;

    // Next state, timer loads and request take.
    always_comb begin
        state_d    = state_q;
        take_o     = 1'b0;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        unique case (state_q)
            S_IDLE: if (pend_i) begin
                state_d = S_STOP_CLK;
                take_o  = 1'b1;
            end
            S_STOP_CLK: begin
                state_d    = S_WAIT_STOP;
                tmr_load_o = 1'b1;
                tmr_val_o  = CW'(STOP_CYC - 1);
            end
            S_WAIT_STOP: if (tmr_zero_i) state_d = S_ASSERT_CLR;
            S_ASSERT_CLR: begin
                state_d    = S_HOLD_CLR;
                tmr_load_o = 1'b1;
                tmr_val_o  = CW'(CLR_CYC - 2);
            end
            S_HOLD_CLR: if (tmr_zero_i) begin
                state_d    = S_RELEASE_WAIT;
                tmr_load_o = 1'b1;
                tmr_val_o  = CW'(SETTLE_CYC - 1);
            end
            S_RELEASE_WAIT: if (tmr_zero_i) state_d = S_ENABLE;
            S_ENABLE: state_d = S_IDLE;
            default: state_d = S_ASSERT_CLR;
        endcase
    end

    // State and output registers; reset parks in the clear phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_ASSERT_CLR;
            out_q   <= decode_out(S_ASSERT_CLR);
        end else begin
            state_q <= state_d;
            out_q   <= decode_out(state_d);
        end
    end

    assign ce_o    = out_q.ce;
    assign clr_n_o = out_q.clr_n;
    assign busy_o  = out_q.busy;
    assign done_o  = out_q.done;

    // Checker counter: cycles with clear high and clock stopped since the clear.
    logic [CW:0] settle_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !out_q.clr_n)                    settle_q <= '0;
        else if (!out_q.ce && settle_q != {(CW+1){1'b1}}) settle_q <= settle_q + 1'b1;
    end

    // R1: the clock is already stopped when the clear falls.
    a_r1_stop_before_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clr_n_o) |-> !$past(ce_o));
    // R2: the clock enable is never high while the clear is low.
    a_r2_no_ce_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_o |-> !ce_o);
    // R3: the enable rises only after the full settle interval.
    a_r3_settle_met: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_o) |-> (settle_q >= (CW+1)'(SETTLE_CYC)));
    // R4: done is a single cycle and coincides with the enable.
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r4_done_with_ce: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ce_o && busy_o));

endmodule

// File: rtl/leaf_clr_seq.sv
// Top of the leaf divider clear sequencer. Phase lengths are in control-clock
// cycles; the clear time is raised to a floor of 4 and the settle and stop
// waits to a floor of 1. Assumes the buffer takes the enable synchronously.
module leaf_clr_seq #(
    parameter int STOP_CYC   = 8,
    parameter int CLR_CYC    = 4,
    parameter int SETTLE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_req_i,
    output logic busy_o,
    output logic done_o,
    output logic buf_ce_o,
    output logic leaf_clr_n_o
);

    localparam int STOP_EFF   = (STOP_CYC   < 1) ? 1 : STOP_CYC;
    localparam int CLR_EFF    = (CLR_CYC    < 4) ? 4 : CLR_CYC;
    localparam int SETTLE_EFF = (SETTLE_CYC < 1) ? 1 : SETTLE_CYC;
    localparam int MAX_A      = (STOP_EFF > CLR_EFF) ? STOP_EFF : CLR_EFF;
    localparam int MAX_C      = (MAX_A > SETTLE_EFF) ? MAX_A : SETTLE_EFF;
    localparam int CW         = $clog2(MAX_C + 1);

    logic          pend;
    logic          take;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;

    lcs_req_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (clr_req_i),
        .take_i (take),
        .pend_o (pend)
    );

    lcs_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    lcs_fsm #(
        .STOP_CYC   (STOP_EFF),
        .CLR_CYC    (CLR_EFF),
        .SETTLE_CYC (SETTLE_EFF),
        .CW         (CW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (pend),
        .tmr_zero_i (tmr_zero),
        .take_o     (take),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .ce_o       (buf_ce_o),
        .clr_n_o    (leaf_clr_n_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    // R6: a pending request in idle always leads to a busy cycle next.
    a_r6_idle_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !busy_o) |=> busy_o);

endmodule

// File: tb/tb_leaf_clr_seq.sv
// Scoreboard bench: expected output phases {busy,ce,clr_n,done} with lengths
// (0 = any length) are queued by the driver, and the monitor pops and compares
// each phase when it ends. It also models the buffer and its dividers.
module tb_leaf_clr_seq;

    localparam int STOP   = 8;
    localparam int CLR    = 4;
    localparam int SETTLE = 2;

    typedef struct {
        logic [3:0] bits;
        int         len;
        string      tag;
    } seg_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic busy, done, ce, clr_n;

    int total = 0;
    int bad = 0;
    seg_t q[$];
    bit   mon_on = 1'b0;
    bit   have_prev = 1'b0;
    logic [3:0] prev;
    int   run = 0;

    always #4 clk = ~clk;

    leaf_clr_seq #(.STOP_CYC(STOP), .CLR_CYC(CLR), .SETTLE_CYC(SETTLE)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_req_i    (req),
        .busy_o       (busy),
        .done_o       (done),
        .buf_ce_o     (ce),
        .leaf_clr_n_o (clr_n)
    );

    // Buffer and divider model: enable taken on the buffer clock (3 ns period).
    logic bclk = 1'b0;
    logic ce_s = 1'b0;
    logic [2:0] dcnt = 3'd0;
    logic gclk;
    logic seen_clr = 1'b0;
    int   bad_edges = 0;
    int   run_edges = 0;
    always #1.5 bclk = ~bclk;
    always @(negedge bclk) ce_s <= (ce === 1'b1);
    assign gclk = bclk & ce_s;
    always @(posedge gclk or negedge clr_n) begin
        if (!clr_n) dcnt <= 3'd0;
        else        dcnt <= dcnt + 3'd1;
    end
    wire d2 = ~dcnt[0];
    wire d4 = ~dcnt[1];
    wire d8 = ~dcnt[2];
    always @(negedge clr_n) seen_clr = 1'b1;
    always @(posedge ce) seen_clr = 1'b0;
    always @(posedge gclk) begin
        run_edges++;
        if (clr_n !== 1'b1 || seen_clr) bad_edges++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push(input logic [3:0] b, input int l, input string t);
        seg_t s;
        s.bits = b; s.len = l; s.tag = t;
        q.push_back(s);
    endtask

    // One full sequence, then an idle phase of the given length.
    task automatic push_seq(input int idle_len, input string idle_tag);
        push(4'b1010, STOP + 1, "R1");
        push(4'b1000, CLR, "R2");
        push(4'b1010, SETTLE, "R3");
        push(4'b1111, 1, "R4");
        push(4'b0110, idle_len, idle_tag);
    endtask

    task automatic close_seg(input logic [3:0] b, input int l);
        seg_t e;
        if (q.size() == 0) begin
            chk(1'b0, "R5 unexpected phase", int'(b), 0);
        end else begin
            e = q.pop_front();
            chk(b == e.bits, {e.tag, " phase levels"}, int'(b), int'(e.bits));
            chk(e.len == 0 || e.len == l, {e.tag, " phase length"}, l, e.len);
        end
    endtask

    // Monitor: segments the output vector and checks divider state at edges.
    always @(negedge clk) begin
        if (mon_on) begin
            logic [3:0] cur;
            cur = {busy, ce, clr_n, done};
            if (!have_prev) begin
                prev = cur; run = 1; have_prev = 1'b1;
            end else if (cur == prev) begin
                run++;
            end else begin
                close_seg(prev, run);
                if (!prev[1] && cur[1])
                    chk({d2, d4, d8} == 3'b111, "R8 dividers high at release", int'({d2, d4, d8}), 7);
                if (!prev[0] && cur[0])
                    chk(bad_edges == 0, "R8 no edges while cleared/settling", bad_edges, 0);
                prev = cur; run = 1;
            end
        end
    end

    task automatic pulse_req();
        @(negedge clk); #1 req = 1'b1;
        @(negedge clk); #1 req = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet;
        quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            if (busy === 1'b0) quiet++; else quiet = 0;
        end
    endtask

    task automatic do_reset();
        mon_on = 1'b0;
        have_prev = 1'b0;
        q.delete();
        @(negedge clk); #1 rst_n = 1'b0; req = 1'b1;
        for (int i = 0; i < 4; i++) @(negedge clk);
        chk({busy, ce, clr_n, done} == 4'b1000, "R6 outputs in reset",
            int'({busy, ce, clr_n, done}), 8);
        #1 req = 1'b0; rst_n = 1'b1; mon_on = 1'b1;
        push(4'b1000, 0, "R6");
        push(4'b1010, SETTLE, "R6");
        push(4'b1111, 1, "R6");
        push(4'b0110, 0, "R6");
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Driver.
    initial begin
        do_reset();
        wait_idle();

        push_seq(0, "R1");          // single request from idle
        pulse_req();
        wait_idle();

        push_seq(1, "R5");          // three requests merge into one follow-up
        push_seq(0, "R5");
        pulse_req();
        repeat (3) @(negedge clk);
        pulse_req();
        repeat (6) @(negedge clk);
        pulse_req();
        wait_idle();

        push_seq(1, "R7");          // request lands in the done cycle
        push_seq(0, "R7");
        pulse_req();
        do @(negedge clk); while (done !== 1'b1);
        #1 req = 1'b1;
        @(negedge clk); #1 req = 1'b0;
        wait_idle();

        pulse_req();                // reset cuts a sequence short
        repeat (3) @(negedge clk);
        do_reset();
        wait_idle();
        repeat (20) @(negedge clk);

        chk(q.size() == 1, "R5 no extra sequence", q.size(), 1);
        chk(run_edges > 0, "R8 dividers clocked after enable", run_edges, 1);
        chk({busy, ce, clr_n, done} == 4'b0110, "R4 idle levels",
            int'({busy, ce, clr_n, done}), 6);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule